// File: doc/BRIEF.md
# Register-Mapped Reconfiguration-Port Bridge

This block sits between a processor's simple register bus and the dynamic reconfiguration port of a clock synthesizer. Software reaches the synthesizer's internal configuration words one at a time. It packs a whole port transaction into a single command word: a launch flag, a read/write flag, the port address and the write data. It then polls a status word. That status word shows whether the port is still busy and holds the data from the most recent read.

Two more registers drive plain output pins. One holds the synthesizer's reset release and enable bits. The other holds the index of the reference clock source. Every port transaction pulses the port enable for a single clock and then waits for the synthesizer's ready pulse. Commands that arrive while a transaction is open are discarded.

Top module: `drp_regbridge`

## Requirements
- R1: After reset, `ctl_run` and `ctl_synth_on` are 0, `src_sel` is 0, the status word reads 0 (not busy, read data 0), and `port_en`/`port_we` are low.
- R2: A write to offset 0x40 stores bits 1:0. Bit 0 drives `ctl_run` and bit 1 drives `ctl_synth_on`. A read of 0x40 returns those two bits, with all other bits zero.
- R3: A write to offset 0x44 stores the low `SRC_W` bits (default 1). They drive `src_sel` and read back at 0x44, with upper bits zero.
- R4: A write to offset 0x70 with bit 29 set launches a transaction. Bit 28 set means read and clear means write. Bits 22:16 give `port_addr` and bits 15:0 give `port_wdata`. Bits 31:30 and 27:23 have no effect.
- R5: The status word at offset 0x74 has busy in bit 16 and the last read data in bits 15:0. Busy reads 1 from the cycle after a command is accepted, and still reads 1 in the cycle `port_rdy` is high. It reads 0 from the next cycle, and a read transaction's `port_rdata` is latched in that same cycle. A write transaction leaves bits 15:0 unchanged.
- R6: `port_en` is high for exactly one clock per transaction: the first cycle that busy is set. `port_we` is high only together with `port_en`, and only for write transactions.
- R7: A write to 0x70 with bit 29 clear starts nothing. A command written while busy is set is dropped, including one in the cycle `port_rdy` is high. A dropped command leaves the open transaction and the port's contents unchanged.
- R8: A `port_rdy` pulse while not busy has no effect on busy or the status data.
- R9: Register read data appears on `bus_rdata` in the cycle after `bus_rd`. Reads of any other offset, including 0x70, return 0, and writes to other offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, one cycle after `bus_rd` |
| ctl_run | output | 1 | Synthesizer general reset release |
| ctl_synth_on | output | 1 | Synthesizer enable |
| src_sel | output | 1 | Reference clock source index |
| port_en | output | 1 | Reconfiguration port enable pulse |
| port_we | output | 1 | Reconfiguration port write enable |
| port_addr | output | 7 | Reconfiguration port address |
| port_wdata | output | 16 | Reconfiguration port write data |
| port_rdata | input | 16 | Reconfiguration port read data |
| port_rdy | input | 1 | Reconfiguration port ready pulse |

## Verification
The sharp overlap is a new command landing in the very cycle the synthesizer returns ready. At that moment the open transaction is closing but busy is still set. The bench watches `port_rdy` at the falling edge and drives a fresh launch command into that same cycle. The command must be dropped: the count of enable pulses must not grow, and the port location it named must keep its old contents. A status read placed in the ready cycle must still show busy, and the read that follows must show it clear with the new data.

// File: rtl/drp_bridge_pkg.sv
package drp_bridge_pkg;

   localparam int BUS_AW = 8;
   localparam int BUS_DW = 32;

   localparam logic [BUS_AW-1:0] OFS_CTRL = 8'h40;
   localparam logic [BUS_AW-1:0] OFS_SRC  = 8'h44;
   localparam logic [BUS_AW-1:0] OFS_CMD  = 8'h70;
   localparam logic [BUS_AW-1:0] OFS_STAT = 8'h74;

   localparam int CMD_GO_BIT    = 29;
   localparam int CMD_RD_BIT    = 28;
   localparam int CMD_ADDR_LSB  = 16;
   localparam int STAT_BUSY_BIT = 16;
   localparam int CTRL_RUN_BIT  = 0;
   localparam int CTRL_ON_BIT   = 1;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CTRL,
      SEL_SRC,
      SEL_CMD,
      SEL_STAT
   } reg_sel_e;

   typedef enum logic {
      SEQ_IDLE,
      SEQ_WAIT
   } seq_state_e;

endpackage

// File: rtl/drp_bridge_regs.sv
module drp_bridge_regs
   import drp_bridge_pkg::*;
#(
   parameter int PAW      = 7,
   parameter int PDW      = 16,
   parameter int SRC_W    = 1,
   parameter bit RDATA_FF = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [BUS_DW-1:0] bus_wdata,
   output logic [BUS_DW-1:0] bus_rdata,
   input  logic              busy,
   input  logic [PDW-1:0]    last_rd,
   output logic              ctl_run,
   output logic              ctl_synth_on,
   output logic [SRC_W-1:0]  src_sel,
   output logic              cmd_req,
   output logic              cmd_rd,
   output logic [PAW-1:0]    cmd_addr,
   output logic [PDW-1:0]    cmd_data
);

   reg_sel_e          sel;
   logic [1:0]        ctrl_q;
   logic [SRC_W-1:0]  src_q;
   logic [BUS_DW-1:0] rd_mux;
   logic              unused_wd;

   assign unused_wd = ^bus_wdata;

   always_comb begin
      unique case (bus_addr)
         OFS_CTRL: sel = SEL_CTRL;
         OFS_SRC:  sel = SEL_SRC;
         OFS_CMD:  sel = SEL_CMD;
         OFS_STAT: sel = SEL_STAT;
         default:  sel = SEL_NONE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         src_q  <= '0;
      end else if (bus_wr) begin
         if (sel == SEL_CTRL) ctrl_q <= bus_wdata[1:0];
         if (sel == SEL_SRC)  src_q  <= bus_wdata[SRC_W-1:0];
      end
   end

   assign ctl_run      = ctrl_q[CTRL_RUN_BIT];
   assign ctl_synth_on = ctrl_q[CTRL_ON_BIT];
   assign src_sel      = src_q;

   // Command fields are decoded straight from the write data.
   assign cmd_req  = bus_wr && (sel == SEL_CMD) && bus_wdata[CMD_GO_BIT];
   assign cmd_rd   = bus_wdata[CMD_RD_BIT];
   assign cmd_addr = bus_wdata[CMD_ADDR_LSB +: PAW];
   assign cmd_data = bus_wdata[PDW-1:0];

   always_comb begin
      rd_mux = '0;
      case (sel)
         SEL_CTRL: rd_mux[1:0] = ctrl_q;
         SEL_SRC:  rd_mux[SRC_W-1:0] = src_q;
         SEL_STAT: begin
            rd_mux[PDW-1:0]       = last_rd;
            rd_mux[STAT_BUSY_BIT] = busy;
         end
         default: rd_mux = '0;
      endcase
   end

   generate
      if (RDATA_FF) begin : g_rd_ff
         always_ff @(posedge clk) begin
            if (!rst_n)      bus_rdata <= '0;
            else if (bus_rd) bus_rdata <= rd_mux;
         end
      end else begin : g_rd_comb
         assign bus_rdata = bus_rd ? rd_mux : '0;
      end
   endgenerate

endmodule

// File: rtl/drp_bridge_seq.sv
module drp_bridge_seq
   import drp_bridge_pkg::*;
#(
   parameter int PAW = 7,
   parameter int PDW = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cmd_req,
   input  logic           cmd_rd,
   input  logic [PAW-1:0] cmd_addr,
   input  logic [PDW-1:0] cmd_data,
   output logic           busy,
   output logic [PDW-1:0] last_rd,
   output logic           port_en,
   output logic           port_we,
   output logic [PAW-1:0] port_addr,
   output logic [PDW-1:0] port_wdata,
   input  logic [PDW-1:0] port_rdata,
   input  logic           port_rdy
);

   seq_state_e state;
   logic       op_rd;

   assign busy = (state == SEQ_WAIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= SEQ_IDLE;
         op_rd      <= 1'b0;
         port_en    <= 1'b0;
         port_we    <= 1'b0;
         port_addr  <= '0;
         port_wdata <= '0;
         last_rd    <= '0;
      end else begin
         port_en <= 1'b0;
         port_we <= 1'b0;
         unique case (state)
            SEQ_IDLE: begin
               if (cmd_req) begin
                  state      <= SEQ_WAIT;
                  op_rd      <= cmd_rd;
                  port_en    <= 1'b1;
                  port_we    <= !cmd_rd;
                  port_addr  <= cmd_addr;
                  port_wdata <= cmd_data;
               end
            end
            SEQ_WAIT: begin
               if (port_rdy) begin
                  state <= SEQ_IDLE;
                  if (op_rd) last_rd <= port_rdata;
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/drp_regbridge.sv
module drp_regbridge
   import drp_bridge_pkg::*;
#(
   parameter int PAW      = 7,
   parameter int PDW      = 16,
   parameter int SRC_W    = 1,
   parameter bit RDATA_FF = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [BUS_DW-1:0] bus_wdata,
   output logic [BUS_DW-1:0] bus_rdata,
   output logic              ctl_run,
   output logic              ctl_synth_on,
   output logic [SRC_W-1:0]  src_sel,
   output logic              port_en,
   output logic              port_we,
   output logic [PAW-1:0]    port_addr,
   output logic [PDW-1:0]    port_wdata,
   input  logic [PDW-1:0]    port_rdata,
   input  logic              port_rdy
);

   localparam int ADDR_TOP = CMD_ADDR_LSB + PAW - 1;

   generate
      if (ADDR_TOP >= CMD_RD_BIT) begin : g_bad_paw
         $error("port address field overlaps command flags");
      end
      if (PDW > STAT_BUSY_BIT) begin : g_bad_pdw
         $error("port data wider than status data field");
      end
      if (SRC_W < 1 || SRC_W > 8) begin : g_bad_src
         $error("source select width out of range");
      end
   endgenerate

   logic           cmd_req, cmd_rd, seq_busy;
   logic [PAW-1:0] cmd_addr;
   logic [PDW-1:0] cmd_data, last_rd;

   drp_bridge_regs #(
      .PAW(PAW), .PDW(PDW), .SRC_W(SRC_W), .RDATA_FF(RDATA_FF)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .busy(seq_busy), .last_rd(last_rd),
      .ctl_run(ctl_run), .ctl_synth_on(ctl_synth_on), .src_sel(src_sel),
      .cmd_req(cmd_req), .cmd_rd(cmd_rd), .cmd_addr(cmd_addr),
      .cmd_data(cmd_data)
   );

   drp_bridge_seq #(
      .PAW(PAW), .PDW(PDW)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .cmd_req(cmd_req), .cmd_rd(cmd_rd), .cmd_addr(cmd_addr),
      .cmd_data(cmd_data),
      .busy(seq_busy), .last_rd(last_rd),
      .port_en(port_en), .port_we(port_we), .port_addr(port_addr),
      .port_wdata(port_wdata), .port_rdata(port_rdata), .port_rdy(port_rdy)
   );

endmodule

// File: rtl/drp_bridge_chk.sv
module drp_bridge_chk (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic cmd_req,
   input logic port_en,
   input logic port_we,
   input logic port_rdy
);

   // R6: enable lasts one clock only
   a_r6_en_single: assert property (@(posedge clk) disable iff (!rst_n)
      port_en |=> !port_en);

   // R6: write enable only alongside enable
   a_r6_we_with_en: assert property (@(posedge clk) disable iff (!rst_n)
      port_we |-> port_en);

   // R6: enable marks the first busy cycle
   a_r6_en_on_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
      port_en |-> $rose(busy));

   // R5: accepted command raises busy and pulses enable next cycle
   a_r5_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req && !busy) |=> (busy && port_en));

   // R5: ready closes the transaction
   a_r5_rdy_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && port_rdy) |=> !busy);

   // R7: a command while busy launches nothing
   a_r7_drop_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req && busy) |=> !port_en);

   // R8: stray ready while idle leaves busy clear
   a_r8_idle_rdy: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && port_rdy && !cmd_req) |=> !busy);

endmodule

bind drp_regbridge drp_bridge_chk u_chk (
   .clk(clk), .rst_n(rst_n), .busy(seq_busy), .cmd_req(cmd_req),
   .port_en(port_en), .port_we(port_we), .port_rdy(port_rdy)
);

// File: tb/drp_regbridge_tb.sv
module drp_regbridge_tb;

   localparam logic [7:0] A_CTRL = 8'h40;
   localparam logic [7:0] A_SRC  = 8'h44;
   localparam logic [7:0] A_CMD  = 8'h70;
   localparam logic [7:0] A_STAT = 8'h74;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        ctl_run, ctl_synth_on;
   logic [0:0]  src_sel;
   logic        port_en, port_we;
   logic [6:0]  port_addr;
   logic [15:0] port_wdata;
   logic [15:0] port_rdata = '0;
   logic        port_rdy;
   logic        rsp_rdy = 1'b0, stray_rdy = 1'b0;

   int n_cmp = 0, n_bad = 0;
   int lat = 2;
   int en_cnt = 0, en_double = 0;
   logic prev_en = 1'b0;

   logic [15:0] mem [128];
   int          cnt = 0;
   logic        p_we = 1'b0;
   logic [6:0]  p_a = '0;
   logic [15:0] p_d = '0;

   always #10 clk = ~clk;

   assign port_rdy = rsp_rdy | stray_rdy;

   drp_regbridge u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ctl_run(ctl_run), .ctl_synth_on(ctl_synth_on), .src_sel(src_sel),
      .port_en(port_en), .port_we(port_we), .port_addr(port_addr),
      .port_wdata(port_wdata), .port_rdata(port_rdata), .port_rdy(port_rdy)
   );

   // Simple port responder with programmable latency
   always @(posedge clk) begin
      rsp_rdy <= 1'b0;
      if (!rst_n) begin
         cnt <= 0;
      end else if (port_en) begin
         cnt  <= lat;
         p_we <= port_we;
         p_a  <= port_addr;
         p_d  <= port_wdata;
      end else if (cnt != 0) begin
         cnt <= cnt - 1;
         if (cnt == 1) begin
            rsp_rdy <= 1'b1;
            if (p_we) mem[p_a] <= p_d;
            else port_rdata <= mem[p_a];
         end
      end
   end

   always @(posedge clk) begin
      if (rst_n) begin
         if (port_en) en_cnt <= en_cnt + 1;
         if (port_en && prev_en) en_double <= en_double + 1;
      end
      prev_en <= port_en;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic wait_idle(output logic [31:0] st);
      st = 32'h0001_0000;
      for (int i = 0; i < 50 && st[16]; i++) reg_rd(A_STAT, st);
   endtask

   function automatic logic [15:0] pat(input int a);
      return 16'((a * 997 + 321) ^ (a << 9));
   endfunction

   function automatic logic [31:0] cmd(input bit rd, input int a, input logic [15:0] d);
      return {2'b11, 1'b1, rd, 5'h1f, 7'(a), d};
   endfunction

   initial begin
      logic [31:0] r, st;
      int e0;
      for (int i = 0; i < 128; i++) mem[i] = 16'hdead;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 ctl_run", 32'(ctl_run), 0);
      chk("R1 ctl_synth_on", 32'(ctl_synth_on), 0);
      chk("R1 src_sel", 32'(src_sel), 0);
      chk("R1 port_en", 32'(port_en), 0);
      reg_rd(A_STAT, r); chk("R1 status", r, 0);
      reg_rd(A_CTRL, r); chk("R1 ctrl", r, 0);

      // R2 control register
      reg_wr(A_CTRL, 32'hffff_fff1);
      chk("R2 run pin", 32'(ctl_run), 1);
      chk("R2 on pin", 32'(ctl_synth_on), 0);
      reg_rd(A_CTRL, r); chk("R2 readback", r, 32'h1);
      reg_wr(A_CTRL, 32'h3);
      chk("R2 on pin", 32'(ctl_synth_on), 1);
      reg_rd(A_CTRL, r); chk("R2 readback", r, 32'h3);

      // R3 source select
      reg_wr(A_SRC, 32'h7);
      chk("R3 pin", 32'(src_sel), 1);
      reg_rd(A_SRC, r); chk("R3 readback", r, 1);
      reg_wr(A_SRC, 32'h2);
      reg_rd(A_SRC, r); chk("R3 readback", r, 0);

      // R9 unmapped offsets
      reg_wr(8'h48, 32'hffff_ffff);
      reg_rd(A_CTRL, r); chk("R9 ctrl unchanged", r, 32'h3);
      reg_rd(8'h48, r);  chk("R9 unmapped read", r, 0);
      reg_rd(A_CMD, r);  chk("R9 command read", r, 0);

      // R4/R5/R6 exact timing of one write command
      lat = 3;
      reg_wr(A_CMD, cmd(1'b0, 5, 16'hbeef));
      chk("R6 en pulse", 32'(port_en), 1);
      chk("R6 we on write", 32'(port_we), 1);
      chk("R4 address", 32'(port_addr), 5);
      chk("R4 data", 32'(port_wdata), 32'hbeef);
      reg_rd(A_STAT, r);
      chk("R5 busy after accept", r, 32'h0001_0000);
      chk("R6 en dropped", 32'(port_en), 0);
      wait_idle(st);
      chk("R5 status idle after write", st, 0);

      // R5 busy still set in ready cycle, clear after, data latched
      reg_wr(A_CMD, cmd(1'b1, 5, 16'h0));
      chk("R6 we low on read", 32'(port_we), 0);
      while (!port_rdy) @(negedge clk);
      reg_rd(A_STAT, r); chk("R5 busy in ready cycle", r, 32'h0001_0000);
      reg_rd(A_STAT, r); chk("R5 read data", r, 32'h0000_beef);

      // R4/R5 sweep: every port address, varied latency
      for (int a = 0; a < 128; a++) begin
         lat = 1 + (a % 4);
         reg_wr(A_CMD, cmd(1'b0, a, pat(a)));
         wait_idle(st);
      end
      for (int a = 0; a < 128; a++) begin
         lat = 1 + ((a + 2) % 4);
         reg_wr(A_CMD, cmd(1'b1, a, 16'h0));
         wait_idle(st);
         chk("R4 R5 sweep readback", st, {16'h0, pat(a)});
      end

      // R7 no launch flag
      e0 = en_cnt;
      reg_wr(A_CMD, 32'h1000_0003 & ~32'h2000_0000);
      repeat (3) @(negedge clk);
      chk("R7 no-go command", 32'(en_cnt), 32'(e0));

      // R7 command while busy dropped
      lat = 6;
      e0 = en_cnt;
      reg_wr(A_CMD, cmd(1'b1, 9, 16'h0));
      reg_wr(A_CMD, cmd(1'b0, 9, 16'h1111));
      wait_idle(st);
      chk("R7 busy drop count", 32'(en_cnt), 32'(e0 + 1));
      chk("R7 open read intact", st, {16'h0, pat(9)});

      // R7 command in the ready cycle dropped
      lat = 3;
      reg_wr(A_CMD, cmd(1'b1, 10, 16'h0));
      while (!port_rdy) @(negedge clk);
      e0 = en_cnt;
      reg_wr(A_CMD, cmd(1'b0, 10, 16'h2222));
      repeat (2) @(negedge clk);
      chk("R7 ready-cycle drop", 32'(en_cnt), 32'(e0));
      reg_wr(A_CMD, cmd(1'b1, 10, 16'h0));
      wait_idle(st);
      chk("R7 location intact", st, {16'h0, pat(10)});

      // R8 stray ready while idle
      stray_rdy = 1'b1;
      @(negedge clk);
      stray_rdy = 1'b0;
      reg_rd(A_STAT, r); chk("R8 stray ready", r, {16'h0, pat(10)});

      chk("R6 no double enable", 32'(en_double), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule